// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block decides, for one privileged instruction at a time, whether the processor may execute it, must raise an illegal-instruction exception, or must raise a virtual-instruction fault. It covers the wait-for-interrupt instruction, the supervisor address-translation fence, the two hypervisor fences (guest-virtual and guest-physical) and the hypervisor's loads and stores on behalf of a virtual machine, including the execute-permission load variant.

The decode stage presents an opcode class with a `req_valid` strobe, together with the current privilege level, the virtualization state, whether supervisor mode is implemented, and the trap-control bits from the status registers. One cycle later the block returns a two-bit verdict. A legal wait instruction also raises a halt request. A legal hypervisor load or store also returns the translation mode that the memory access must use. The block performs no flush and no memory access itself.

Top module: `privop_screen`

## Requirements
- R1: One clock after a cycle with `req_valid` high, `rsp_valid` is high and the other outputs carry that request's result. After a cycle with `req_valid` low, `rsp_valid` is low and the other outputs keep their values. Synchronous reset clears every output to zero.
- R2: Encodings. The verdict is 00 for allowed, 01 for illegal instruction and 10 for virtual-instruction fault, and is never 11. Privilege is 00 for user, 01 for supervisor and 11 for machine. The opcode classes are 0 wait, 1 translation fence, 2 guest-virtual hypervisor fence, 3 guest-physical hypervisor fence, 4 hypervisor load, 5 hypervisor store, 6 hypervisor execute-permission load and 7 reserved.
- R3: A wait instruction is illegal in two cases. The first is when the timeout-wait bit is set and the privilege is supervisor, or user with no supervisor mode implemented. The second is in user mode with supervisor mode implemented while not virtualized. The wait-control bits have no effect in machine mode.
- R4: A wait instruction that R3 does not make illegal raises a virtual fault while virtualized if the privilege is user, or if it is supervisor with the virtual timeout-wait bit set. Otherwise it is allowed and `rsp_halt` is 1.
- R5: A translation fence that is not virtualized is illegal in user mode, and also in supervisor mode with the trap-translation bit set. A virtualized translation fence raises a virtual fault in user mode or when the virtual trap-translation bit is set. In every other case it is allowed.
- R6: Either hypervisor fence raises a virtual fault when virtualized. When not virtualized it is allowed in machine or supervisor mode and illegal in user mode.
- R7: The guest-physical fence is also illegal in non-virtualized supervisor mode when the trap-translation bit is set. The guest-virtual fence ignores that bit.
- R8: A hypervisor load or store is always allowed in machine mode. Otherwise it raises a virtual fault when virtualized, and it is illegal in non-virtualized user mode when the hypervisor-user bit is clear.
- R9: For an allowed hypervisor access, `rsp_xmode` bit 2 is the two-stage flag and is always 1. Bits 1:0 give the level: 00 user when the stored previous-virtual-privilege bit is 0, and 01 supervisor when it is 1. The level becomes 10 (supervisor with user-memory access) when the access is not the execute-permission load and the virtual supervisor's user-memory-access bit is set.
- R10: The reserved opcode class is illegal. `rsp_halt` is 0 except for an allowed wait. `rsp_xmode` is 000 except for an allowed hypervisor access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction present this cycle |
| req_op | input | 3 | Opcode class (R2) |
| req_priv | input | 2 | Current privilege (R2) |
| req_virt | input | 1 | Executing inside a virtual machine |
| cfg_has_smode | input | 1 | Supervisor mode implemented |
| ctl_tw | input | 1 | Timeout-wait trap bit |
| ctl_tvm | input | 1 | Trap translation-management bit |
| ctl_vtw | input | 1 | Virtual timeout-wait trap bit |
| ctl_vtvm | input | 1 | Virtual trap translation-management bit |
| ctl_hu | input | 1 | Hypervisor accesses allowed from user mode |
| hyp_prev_super | input | 1 | Stored previous virtual privilege is supervisor |
| vs_user_access | input | 1 | Virtual supervisor may touch user pages |
| rsp_valid | output | 1 | Result present |
| rsp_verdict | output | 2 | Allowed / illegal / virtual fault |
| rsp_halt | output | 1 | Halt request for an allowed wait |
| rsp_xmode | output | 3 | Translation mode for an allowed hypervisor access |

## Verification
Every result is due exactly one clock edge after the edge that samples `req_valid`. The directed tasks drive a request on a falling edge, drop the strobe on the next falling edge and compare all outputs there, half a period after the registering edge. The idle checks then wait further falling edges with the strobe low and confirm that `rsp_valid` has dropped and that the verdict, halt and mode are unchanged. For each opcode class, the priority cases are applied with single control bits toggled, so that an illegal-instruction condition is seen to win over a virtual fault wherever both could apply.

// File: rtl/privop_pkg.sv
`timescale 1ns/1ps
package privop_pkg;

    localparam int OP_W      = 3;
    localparam int PRIV_W    = 2;
    localparam int VERDICT_W = 2;
    localparam int LVL_W     = 2;
    localparam int XMODE_W   = LVL_W + 1;

    typedef enum logic [PRIV_W-1:0] {
        PRV_USER  = 2'b00,
        PRV_SUPER = 2'b01,
        PRV_MACH  = 2'b11
    } priv_e;

    typedef enum logic [OP_W-1:0] {
        OP_WAIT     = 3'd0,
        OP_FENCE_VM = 3'd1,
        OP_HFENCE_V = 3'd2,
        OP_HFENCE_G = 3'd3,
        OP_HLOAD    = 3'd4,
        OP_HSTORE   = 3'd5,
        OP_HLOAD_X  = 3'd6,
        OP_RSVD     = 3'd7
    } op_e;

    typedef enum logic [VERDICT_W-1:0] {
        VERDICT_OK   = 2'b00,
        VERDICT_ILL  = 2'b01,
        VERDICT_VIRT = 2'b10
    } verdict_e;

    localparam logic [LVL_W-1:0] LVL_USER      = 2'b00;
    localparam logic [LVL_W-1:0] LVL_SUPER     = 2'b01;
    localparam logic [LVL_W-1:0] LVL_SUPER_SUM = 2'b10;

    typedef struct packed {
        logic              two_stage;
        logic [LVL_W-1:0]  lvl;
    } xmode_t;

    typedef struct packed {
        priv_e priv;
        logic  virt;
        logic  has_s;
        logic  tw;
        logic  tvm;
        logic  vtw;
        logic  vtvm;
        logic  hu;
        logic  prev_super;
        logic  vs_sum;
    } ctx_t;

    typedef struct packed {
        verdict_e verdict;
        logic     halt;
        xmode_t   xmode;
    } outcome_t;

    localparam xmode_t XMODE_NONE = '{two_stage: 1'b0, lvl: LVL_USER};

    function automatic logic is_hyp_access(op_e op);
        return (op == OP_HLOAD) || (op == OP_HSTORE) || (op == OP_HLOAD_X);
    endfunction

    function automatic logic is_hyp_fence(op_e op);
        return (op == OP_HFENCE_V) || (op == OP_HFENCE_G);
    endfunction

endpackage

// File: rtl/privop_wait_rule.sv
`timescale 1ns/1ps
module privop_wait_rule
    import privop_pkg::*;
(
    input  ctx_t     ctx,
    output verdict_e verdict,
    output logic     halt
);
    logic in_user;
    logic in_super;
    logic trap_ill;
    logic trap_virt;

    assign in_user  = (ctx.priv == PRV_USER);
    assign in_super = (ctx.priv == PRV_SUPER);

    // R3: timeout-wait trap, or user wait with supervisor present outside a guest
    assign trap_ill  = ((in_super || (!ctx.has_s && in_user)) && ctx.tw)
                     || (ctx.has_s && in_user && !ctx.virt);
    // R4: guest user, or guest supervisor with virtual timeout-wait
    assign trap_virt = ctx.virt && (in_user || (in_super && ctx.vtw));

    always_comb begin
        verdict = VERDICT_OK;
        halt    = 1'b0;
        if (trap_ill) begin
            verdict = VERDICT_ILL;
        end else if (trap_virt) begin
            verdict = VERDICT_VIRT;
        end else begin
            halt = 1'b1;
        end
    end
endmodule

// File: rtl/privop_fence_rule.sv
`timescale 1ns/1ps
module privop_fence_rule
    import privop_pkg::*;
(
    input  op_e      op,
    input  ctx_t     ctx,
    output verdict_e verdict
);
    logic in_user;
    logic in_super;
    logic in_mach;

    assign in_user  = (ctx.priv == PRV_USER);
    assign in_super = (ctx.priv == PRV_SUPER);
    assign in_mach  = (ctx.priv == PRV_MACH);

    always_comb begin
        verdict = VERDICT_OK;
        unique case (op)
            OP_FENCE_VM: begin
                // R5
                if (!ctx.virt) begin
                    if (in_user || (in_super && ctx.tvm)) verdict = VERDICT_ILL;
                end else if (in_user || ctx.vtvm) begin
                    verdict = VERDICT_VIRT;
                end
            end
            OP_HFENCE_V, OP_HFENCE_G: begin
                // R7 ahead of R6
                if (op == OP_HFENCE_G && in_super && !ctx.virt && ctx.tvm) begin
                    verdict = VERDICT_ILL;
                end else if (ctx.virt) begin
                    verdict = VERDICT_VIRT;
                end else if (!(in_mach || in_super)) begin
                    verdict = VERDICT_ILL;
                end
            end
            default: verdict = VERDICT_ILL;
        endcase
    end
endmodule

// File: rtl/privop_hyp_rule.sv
`timescale 1ns/1ps
module privop_hyp_rule
    import privop_pkg::*;
(
    input  op_e      op,
    input  ctx_t     ctx,
    output verdict_e verdict,
    output xmode_t   xmode
);
    logic       sum_applies;
    xmode_t     mode_calc;

    // R8
    always_comb begin
        verdict = VERDICT_OK;
        if (ctx.priv == PRV_MACH) begin
            verdict = VERDICT_OK;
        end else if (ctx.virt) begin
            verdict = VERDICT_VIRT;
        end else if (ctx.priv == PRV_USER && !ctx.hu) begin
            verdict = VERDICT_ILL;
        end
    end

    // R9: execute-permission loads never take the user-access override
    assign sum_applies = (op != OP_HLOAD_X) && ctx.prev_super && ctx.vs_sum;

    always_comb begin
        mode_calc.two_stage = 1'b1;
        if (sum_applies)         mode_calc.lvl = LVL_SUPER_SUM;
        else if (ctx.prev_super) mode_calc.lvl = LVL_SUPER;
        else                     mode_calc.lvl = LVL_USER;
    end

    assign xmode = (verdict == VERDICT_OK) ? mode_calc : XMODE_NONE;
endmodule

// File: rtl/privop_screen.sv
`timescale 1ns/1ps
module privop_screen
    import privop_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [OP_W-1:0]      req_op,
    input  logic [PRIV_W-1:0]    req_priv,
    input  logic                 req_virt,
    input  logic                 cfg_has_smode,
    input  logic                 ctl_tw,
    input  logic                 ctl_tvm,
    input  logic                 ctl_vtw,
    input  logic                 ctl_vtvm,
    input  logic                 ctl_hu,
    input  logic                 hyp_prev_super,
    input  logic                 vs_user_access,
    output logic                 rsp_valid,
    output logic [VERDICT_W-1:0] rsp_verdict,
    output logic                 rsp_halt,
    output logic [XMODE_W-1:0]   rsp_xmode
);
    op_e      op;
    ctx_t     ctx;
    verdict_e wait_v;
    logic     wait_halt;
    verdict_e fence_v;
    verdict_e hyp_v;
    xmode_t   hyp_mode;
    outcome_t next_out;
    outcome_t held;

    assign op             = op_e'(req_op);
    assign ctx.priv       = priv_e'(req_priv);
    assign ctx.virt       = req_virt;
    assign ctx.has_s      = cfg_has_smode;
    assign ctx.tw         = ctl_tw;
    assign ctx.tvm        = ctl_tvm;
    assign ctx.vtw        = ctl_vtw;
    assign ctx.vtvm       = ctl_vtvm;
    assign ctx.hu         = ctl_hu;
    assign ctx.prev_super = hyp_prev_super;
    assign ctx.vs_sum     = vs_user_access;

    privop_wait_rule u_wait (
        .ctx     (ctx),
        .verdict (wait_v),
        .halt    (wait_halt)
    );

    privop_fence_rule u_fence (
        .op      (op),
        .ctx     (ctx),
        .verdict (fence_v)
    );

    privop_hyp_rule u_hyp (
        .op      (op),
        .ctx     (ctx),
        .verdict (hyp_v),
        .xmode   (hyp_mode)
    );

    // R10: only the owning rule may raise halt or a mode
    always_comb begin
        next_out = '{verdict: VERDICT_ILL, halt: 1'b0, xmode: XMODE_NONE};
        if (op == OP_WAIT) begin
            next_out.verdict = wait_v;
            next_out.halt    = wait_halt;
        end else if (op == OP_FENCE_VM || is_hyp_fence(op)) begin
            next_out.verdict = fence_v;
        end else if (is_hyp_access(op)) begin
            next_out.verdict = hyp_v;
            next_out.xmode   = hyp_mode;
        end
    end

    // R1: one register stage, updated only on a strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            held      <= '{verdict: VERDICT_OK, halt: 1'b0, xmode: XMODE_NONE};
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) held <= next_out;
        end
    end

    assign rsp_verdict = held.verdict;
    assign rsp_halt    = held.halt;
    assign rsp_xmode   = held.xmode;

    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && $stable(rsp_verdict) && $stable(rsp_xmode)));

    assert_verdict_code_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_verdict != 2'b11);

    assert_mach_wait_halts_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_WAIT && req_priv == PRV_MACH) |=> rsp_halt);

    assert_user_fence_traps_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_FENCE_VM && req_priv == PRV_USER)
        |=> (rsp_verdict != VERDICT_OK));

    assert_hyp_mach_ok_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv == PRV_MACH && req_op >= OP_HLOAD && req_op <= OP_HLOAD_X)
        |=> (rsp_verdict == VERDICT_OK && rsp_xmode[XMODE_W-1]));

    assert_mode_two_stage_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_xmode != '0) |-> (rsp_xmode[XMODE_W-1] && rsp_verdict == VERDICT_OK));

    assert_halt_only_ok_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_halt |-> (rsp_verdict == VERDICT_OK && rsp_xmode == '0));
endmodule

// File: tb/privop_screen_bench.sv
`timescale 1ns/1ps
module privop_screen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [1:0] req_priv = 2'b11;
    logic       req_virt = 1'b0;
    logic       cfg_has_smode = 1'b1;
    logic       ctl_tw = 1'b0, ctl_tvm = 1'b0, ctl_vtw = 1'b0, ctl_vtvm = 1'b0, ctl_hu = 1'b0;
    logic       hyp_prev_super = 1'b0, vs_user_access = 1'b0;
    logic       rsp_valid;
    logic [1:0] rsp_verdict;
    logic       rsp_halt;
    logic [2:0] rsp_xmode;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;
    localparam logic [1:0] OK = 2'b00, ILL = 2'b01, VF = 2'b10;

    always #10 clk = ~clk;

    privop_screen u_privop_screen (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_priv(req_priv), .req_virt(req_virt), .cfg_has_smode(cfg_has_smode),
        .ctl_tw(ctl_tw), .ctl_tvm(ctl_tvm), .ctl_vtw(ctl_vtw), .ctl_vtvm(ctl_vtvm),
        .ctl_hu(ctl_hu), .hyp_prev_super(hyp_prev_super), .vs_user_access(vs_user_access),
        .rsp_valid(rsp_valid), .rsp_verdict(rsp_verdict), .rsp_halt(rsp_halt),
        .rsp_xmode(rsp_xmode)
    );

    task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got valid/verdict/halt/mode=%b expected %b", tag, got, exp);
        end
    endtask

    task automatic set_ctl(input logic has_s, input logic tw, input logic tvm,
                           input logic vtw, input logic vtvm, input logic hu,
                           input logic prev_s, input logic sum);
        cfg_has_smode = has_s; ctl_tw = tw; ctl_tvm = tvm; ctl_vtw = vtw;
        ctl_vtvm = vtvm; ctl_hu = hu; hyp_prev_super = prev_s; vs_user_access = sum;
    endtask

    // drive on a falling edge, registered on the next rising edge, compare on the falling edge after
    task automatic issue(input string tag, input logic [2:0] op, input logic [1:0] priv,
                         input logic virt, input logic [1:0] exp_v, input logic exp_h,
                         input logic [2:0] exp_m);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_priv = priv; req_virt = virt;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {rsp_valid, rsp_verdict, rsp_halt, rsp_xmode}, {1'b1, exp_v, exp_h, exp_m});
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset state", {rsp_valid, rsp_verdict, rsp_halt, rsp_xmode}, 7'b0);
        rst = 1'b0;
    endtask

    task automatic t_wait;
        set_ctl(1, 1, 0, 1, 0, 0, 0, 0);
        issue("R3 machine wait ignores tw", 3'd0, M, 0, OK, 1, 3'b000);
        issue("R3 supervisor wait with tw", 3'd0, S, 0, ILL, 0, 3'b000);
        set_ctl(0, 1, 0, 0, 0, 0, 0, 0);
        issue("R3 user wait tw no smode", 3'd0, U, 0, ILL, 0, 3'b000);
        issue("R3 tw wins over guest fault", 3'd0, U, 1, ILL, 0, 3'b000);
        set_ctl(0, 0, 0, 0, 0, 0, 0, 0);
        issue("R4 user wait no smode halts", 3'd0, U, 0, OK, 1, 3'b000);
        set_ctl(1, 0, 0, 0, 0, 0, 0, 0);
        issue("R3 user wait with smode host", 3'd0, U, 0, ILL, 0, 3'b000);
        issue("R4 guest user wait", 3'd0, U, 1, VF, 0, 3'b000);
        issue("R4 guest super wait vtw clear", 3'd0, S, 1, OK, 1, 3'b000);
        set_ctl(1, 0, 0, 1, 0, 0, 0, 0);
        issue("R4 guest super wait vtw set", 3'd0, S, 1, VF, 0, 3'b000);
    endtask

    task automatic t_fence;
        set_ctl(1, 0, 1, 0, 0, 0, 0, 0);
        issue("R5 user fence host", 3'd1, U, 0, ILL, 0, 3'b000);
        issue("R5 super fence tvm", 3'd1, S, 0, ILL, 0, 3'b000);
        issue("R5 machine fence ignores tvm", 3'd1, M, 0, OK, 0, 3'b000);
        issue("R5 guest super ignores tvm", 3'd1, S, 1, OK, 0, 3'b000);
        set_ctl(1, 0, 0, 0, 1, 0, 0, 0);
        issue("R5 super fence host vtvm ignored", 3'd1, S, 0, OK, 0, 3'b000);
        issue("R5 guest super vtvm", 3'd1, S, 1, VF, 0, 3'b000);
        set_ctl(1, 0, 0, 0, 0, 0, 0, 0);
        issue("R5 guest user fence", 3'd1, U, 1, VF, 0, 3'b000);
    endtask

    task automatic t_hfence;
        set_ctl(1, 0, 1, 0, 0, 0, 0, 0);
        issue("R6 gv fence machine", 3'd2, M, 0, OK, 0, 3'b000);
        issue("R7 gv fence super ignores tvm", 3'd2, S, 0, OK, 0, 3'b000);
        issue("R6 gv fence guest", 3'd2, S, 1, VF, 0, 3'b000);
        issue("R6 gv fence user host", 3'd2, U, 0, ILL, 0, 3'b000);
        issue("R7 gp fence super tvm", 3'd3, S, 0, ILL, 0, 3'b000);
        issue("R6 gp fence guest tvm", 3'd3, S, 1, VF, 0, 3'b000);
        issue("R6 gp fence machine tvm", 3'd3, M, 0, OK, 0, 3'b000);
        set_ctl(1, 0, 0, 0, 0, 0, 0, 0);
        issue("R6 gp fence super no tvm", 3'd3, S, 0, OK, 0, 3'b000);
    endtask

    task automatic t_hyp;
        set_ctl(1, 0, 0, 0, 0, 0, 1, 1);
        issue("R9 machine load sum mode", 3'd4, M, 0, OK, 0, 3'b110);
        issue("R9 exec load skips sum", 3'd6, M, 0, OK, 0, 3'b101);
        issue("R8 guest store faults", 3'd5, S, 1, VF, 0, 3'b000);
        issue("R8 user load hu clear", 3'd4, U, 0, ILL, 0, 3'b000);
        set_ctl(1, 0, 0, 0, 0, 0, 0, 1);
        issue("R9 super store user level", 3'd5, S, 0, OK, 0, 3'b100);
        set_ctl(1, 0, 0, 0, 0, 1, 1, 0);
        issue("R9 user load hu set super level", 3'd4, U, 0, OK, 0, 3'b101);
        issue("R8 guest user hu set faults", 3'd4, U, 1, VF, 0, 3'b000);
    endtask

    task automatic t_misc;
        set_ctl(1, 0, 0, 0, 0, 1, 1, 1);
        issue("R10 reserved op", 3'd7, M, 0, ILL, 0, 3'b000);
        issue("R10 halt then", 3'd0, M, 0, OK, 1, 3'b000);
        req_op = 3'd1; req_priv = U;
        @(negedge clk);
        check("R1 idle drops valid holds result", {rsp_valid, rsp_verdict, rsp_halt, rsp_xmode},
              {1'b0, OK, 1'b1, 3'b000});
        @(negedge clk);
        check("R1 idle second cycle", {rsp_valid, rsp_verdict, rsp_halt, rsp_xmode},
              {1'b0, OK, 1'b1, 3'b000});
        issue("R2 back to back first", 3'd4, M, 0, OK, 0, 3'b110);
        issue("R2 back to back second", 3'd1, U, 0, ILL, 0, 3'b000);
    endtask

    initial begin
        t_reset();
        t_wait();
        t_fence();
        t_hfence();
        t_hyp();
        t_misc();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule